// File: doc/BRIEF.md
# Ethernet Receive Statistics Monitor

This block sits beside a receive frame stream and gathers traffic statistics for a host. The stream delivers beats of `DATA_BYTES` byte lanes, each marked valid, with start and end markers, a count of unused lanes on the closing beat, and a 6-bit error vector that is only meaningful on the closing beat. The monitor counts good and errored packets, keeps 64-bit byte and clock-cycle totals, and records the error vector and a CRC flag from the latest packet. It also raises a completion flag once a host-programmed number of packets has been seen.

The host reaches eight 32-bit registers through a word-indexed read/write port. Word index = byte offset / 4: 0 packet target (read/write), 1 good packets, 2 errored packets, 3/4 byte total low/high, 5/6 cycle total low/high, 7 control/status. A run is begun by setting START and ends with STOP or on completion. Beginning a run clears every counter and flag, but not the target.

Top module: `rxstat_monitor`

## Requirements
- R1: After reset every register (word indices 0 to 7) reads as zero.
- R2: Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled. Only the target (index 0) and control (index 7) accept writes, and writes to indices 1 to 6 change nothing.
- R3: Writing index 7 with bit 0 set makes START (bit 0) read 1 for exactly one cycle. At the next edge reception becomes active and START reads 0.
- R4: Writing index 7 with bit 1 set ends reception at that edge and sets STOP (bit 1). STOP stays 1, and later beats are ignored, until the next START clears it.
- R5: When reception begins, the good, errored, byte and cycle counters, the done flag, the CRC flag and the error field all return to zero. The target keeps its value.
- R6: An accepted closing beat whose error vector is zero adds one to the good count. Any nonzero vector adds one to the errored count instead, and never both.
- R7: Each accepted beat adds `DATA_BYTES` to the byte total. A closing beat adds `DATA_BYTES` minus its empty-lane count.
- R8: The cycle total grows by one on every clock edge while reception is active, and holds once reception ends.
- R9: Status bit 2 (done) is set on the closing beat that brings good plus errored up to the target. Reception ends on that beat, and later packets leave the counters unchanged.
- R10: Status bit 3 equals bit 1 of the error vector of the latest packet (CRC failure). Bits 9:4 hold that packet's whole error vector, and bits 31:10 read zero.
- R11: Reading a low word (index 3 or 5) stores the matching upper 32 bits. The next read of the high word (index 4 or 6) returns that stored value.
- R12: Beats are ignored while reception is inactive. A beat is also ignored when it neither carries a start marker nor follows one inside the same packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Stream beat valid |
| st_sop | input | 1 | First beat of a packet |
| st_eop | input | 1 | Last beat of a packet |
| st_empty | input | EMPTY_W | Unused byte lanes on the last beat |
| st_err | input | 6 | Error vector, sampled on the last beat |
| bus_word | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
Every counter and flag changes at the edge that samples the beat or write causing it. A read strobe is sampled one edge later, and its data is present on `bus_rdata` at the following falling edge. The bench therefore drives on falling edges and samples read data one half-cycle after the strobe's edge. A register written on the previous cycle is read only after one idle cycle, except where the single-cycle visibility of START is itself the thing under test. For the cycle total, START is written at falling edge n and STOP at falling edge n+1+W. The expected count is exactly W, because the first active edge clears the counter and the STOP edge still counts.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;

    localparam int REG_W = 32;
    localparam int CNT_W = 64;
    localparam int ERR_W = 6;

    // control/status bit positions inside word 7
    localparam int CTL_START   = 0;
    localparam int CTL_STOP    = 1;
    localparam int CTL_DONE    = 2;
    localparam int CTL_CRC     = 3;
    localparam int CTL_ERR_LSB = 4;

    // error vector bit that flags a failed frame check
    localparam int ERR_CRC_BIT = 1;

    typedef enum logic [2:0] {
        IDX_TARGET  = 3'd0,
        IDX_GOOD    = 3'd1,
        IDX_BAD     = 3'd2,
        IDX_BYTE_LO = 3'd3,
        IDX_BYTE_HI = 3'd4,
        IDX_CYC_LO  = 3'd5,
        IDX_CYC_HI  = 3'd6,
        IDX_CTRL    = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic [REG_W-1:0] good;
        logic [REG_W-1:0] bad;
        logic [CNT_W-1:0] bytes;
        logic [CNT_W-1:0] cycles;
    } rx_counts_t;

    typedef struct packed {
        logic [ERR_W-1:0] err;
        logic             crc_bad;
        logic             done;
    } rx_status_t;

    // bytes carried by one beat
    function automatic logic [15:0] lane_bytes(input logic [15:0] lanes,
                                               input logic        last,
                                               input logic [15:0] empty);
        return last ? (lanes - empty) : lanes;
    endfunction

endpackage

// File: rtl/rxstat_ctrl.sv
module rxstat_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  logic stop_req,
    input  logic final_pkt,
    output logic start_bit,
    output logic stop_bit,
    output logic run,
    output logic clr
);

    assign clr = start_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_bit <= 1'b0;
            stop_bit  <= 1'b0;
            run       <= 1'b0;
        end else begin
            if (start_bit) begin
                start_bit <= 1'b0;
                stop_bit  <= 1'b0;
                run       <= 1'b1;
            end else if (run && (stop_req || stop_bit || final_pkt)) begin
                run <= 1'b0;
            end
            if (start_req) start_bit <= 1'b1;
            if (stop_req)  stop_bit  <= 1'b1;
        end
    end

endmodule

// File: rtl/rxstat_counters.sv
module rxstat_counters
    import rxstat_pkg::*;
#(
    parameter int DATA_BYTES = 4,
    parameter int EMPTY_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 run,
    input  logic                 st_valid,
    input  logic                 st_sop,
    input  logic                 st_eop,
    input  logic [EMPTY_W-1:0]   st_empty,
    input  logic [ERR_W-1:0]     st_err,
    input  logic [REG_W-1:0]     target,
    output rx_counts_t           cnt,
    output rx_status_t           stat,
    output logic                 final_pkt
);

    logic             in_pkt;
    logic             beat;
    logic             close_beat;
    logic [REG_W-1:0] pkt_next;
    logic [15:0]      add_bytes;

    assign beat       = run && !clr && st_valid && (st_sop || in_pkt);
    assign close_beat = beat && st_eop;
    assign pkt_next   = cnt.good + cnt.bad + REG_W'(1);
    assign final_pkt  = close_beat && (pkt_next == target);
    assign add_bytes  = lane_bytes(16'(DATA_BYTES), st_eop, 16'(st_empty));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt    <= '0;
            stat   <= '0;
            in_pkt <= 1'b0;
        end else begin
            if (run) cnt.cycles <= cnt.cycles + CNT_W'(1);
            if (beat) begin
                cnt.bytes <= cnt.bytes + CNT_W'(add_bytes);
                in_pkt    <= !st_eop;
            end
            if (close_beat) begin
                if (|st_err) cnt.bad  <= cnt.bad + REG_W'(1);
                else         cnt.good <= cnt.good + REG_W'(1);
                stat.err     <= st_err;
                stat.crc_bad <= st_err[ERR_CRC_BIT];
            end
            if (final_pkt) stat.done <= 1'b1;
        end
    end

endmodule

// File: rtl/rxstat_regs.sv
module rxstat_regs
    import rxstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_word,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    input  rx_counts_t        cnt,
    input  rx_status_t        stat,
    input  logic              start_bit,
    input  logic              stop_bit,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [REG_W-1:0]  target,
    output logic              start_req,
    output logic              stop_req
);

    reg_idx_e         idx;
    logic [REG_W-1:0] shadow_bytes;
    logic [REG_W-1:0] shadow_cyc;
    logic [REG_W-1:0] ctrl_word;
    logic [REG_W-1:0] rd_mux;

    assign idx       = reg_idx_e'(bus_word);
    assign start_req = bus_wr && (idx == IDX_CTRL) && bus_wdata[CTL_START];
    assign stop_req  = bus_wr && (idx == IDX_CTRL) && bus_wdata[CTL_STOP];

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTL_START] = start_bit;
        ctrl_word[CTL_STOP]  = stop_bit;
        ctrl_word[CTL_DONE]  = stat.done;
        ctrl_word[CTL_CRC]   = stat.crc_bad;
        ctrl_word[CTL_ERR_LSB +: ERR_W] = stat.err;
    end

    always_comb begin
        unique case (idx)
            IDX_TARGET:  rd_mux = target;
            IDX_GOOD:    rd_mux = cnt.good;
            IDX_BAD:     rd_mux = cnt.bad;
            IDX_BYTE_LO: rd_mux = cnt.bytes[REG_W-1:0];
            IDX_BYTE_HI: rd_mux = shadow_bytes;
            IDX_CYC_LO:  rd_mux = cnt.cycles[REG_W-1:0];
            IDX_CYC_HI:  rd_mux = shadow_cyc;
            IDX_CTRL:    rd_mux = ctrl_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            target       <= '0;
            shadow_bytes <= '0;
            shadow_cyc   <= '0;
            bus_rdata    <= '0;
        end else begin
            if (bus_wr && idx == IDX_TARGET) target <= bus_wdata;
            if (bus_rd) begin
                bus_rdata <= rd_mux;
                if (idx == IDX_BYTE_LO) shadow_bytes <= cnt.bytes[CNT_W-1:REG_W];
                if (idx == IDX_CYC_LO)  shadow_cyc   <= cnt.cycles[CNT_W-1:REG_W];
            end
        end
    end

endmodule

// File: rtl/rxstat_monitor.sv
module rxstat_monitor
    import rxstat_pkg::*;
#(
    parameter int DATA_BYTES = 4,
    localparam int EMPTY_W   = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               st_valid,
    input  logic               st_sop,
    input  logic               st_eop,
    input  logic [EMPTY_W-1:0] st_empty,
    input  logic [5:0]         st_err,
    input  logic [2:0]         bus_word,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    input  logic               bus_rd,
    output logic [31:0]        bus_rdata
);

    rx_counts_t       cnt;
    rx_status_t       stat;
    logic [REG_W-1:0] target;
    logic             start_req;
    logic             stop_req;
    logic             final_pkt;
    logic             start_bit;
    logic             stop_bit;
    logic             run;
    logic             clr;

    rxstat_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .stop_req  (stop_req),
        .final_pkt (final_pkt),
        .start_bit (start_bit),
        .stop_bit  (stop_bit),
        .run       (run),
        .clr       (clr)
    );

    rxstat_counters #(
        .DATA_BYTES (DATA_BYTES),
        .EMPTY_W    (EMPTY_W)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .run       (run),
        .st_valid  (st_valid),
        .st_sop    (st_sop),
        .st_eop    (st_eop),
        .st_empty  (st_empty),
        .st_err    (st_err),
        .target    (target),
        .cnt       (cnt),
        .stat      (stat),
        .final_pkt (final_pkt)
    );

    rxstat_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_word  (bus_word),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .cnt       (cnt),
        .stat      (stat),
        .start_bit (start_bit),
        .stop_bit  (stop_bit),
        .bus_rdata (bus_rdata),
        .target    (target),
        .start_req (start_req),
        .stop_req  (stop_req)
    );

endmodule

// File: rtl/rxstat_chk.sv
module rxstat_chk
    import rxstat_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        start_bit,
    input logic        stop_bit,
    input logic        start_req,
    input logic        stop_req,
    input logic        run,
    input rx_counts_t  cnt,
    input rx_status_t  stat,
    input logic        bus_rd,
    input logic [2:0]  bus_word,
    input logic [31:0] bus_rdata
);

    // R3
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        start_bit && !start_req |=> !start_bit && run);

    // R4
    stop_halts_chk: assert property (@(posedge clk) disable iff (rst)
        stop_req && !start_bit |=> !run && stop_bit);

    // R5
    clear_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        start_bit |=> cnt.good == '0 && cnt.bad == '0 && cnt.bytes == '0 && !stat.done);

    // R8
    cycle_step_chk: assert property (@(posedge clk) disable iff (rst)
        run && !start_bit |=> cnt.cycles == $past(cnt.cycles) + 64'd1);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run && !start_bit |=> $stable(cnt.bytes) && $stable(cnt.cycles)
                               && $stable(cnt.good) && $stable(cnt.bad));

    // R6
    one_packet_chk: assert property (@(posedge clk) disable iff (rst)
        !start_bit |=> (cnt.good + cnt.bad) - $past(cnt.good + cnt.bad) <= 32'd1);

    // R10
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd && bus_word == 3'd7 |=> bus_rdata[31:10] == 22'd0);

endmodule

bind rxstat_monitor rxstat_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_bit (start_bit),
    .stop_bit  (stop_bit),
    .start_req (start_req),
    .stop_req  (stop_req),
    .run       (run),
    .cnt       (cnt),
    .stat      (stat),
    .bus_rd    (bus_rd),
    .bus_word  (bus_word),
    .bus_rdata (bus_rdata)
);

// File: tb/sim_rxstat_monitor.sv
module sim_rxstat_monitor;

    localparam int LANES = 4;
    localparam int EW    = 2;
    localparam int NPKT  = 12;
    localparam int WIN   = 37;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          st_valid = 1'b0, st_sop = 1'b0, st_eop = 1'b0;
    logic [EW-1:0] st_empty = '0;
    logic [5:0]    st_err = '0;
    logic [2:0]    bus_word = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;

    int vectors = 0;
    int fails   = 0;

    always #10 clk = ~clk;

    rxstat_monitor #(.DATA_BYTES(LANES)) u0 (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_sop(st_sop),
        .st_eop(st_eop), .st_empty(st_empty), .st_err(st_err),
        .bus_word(bus_word), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] w, input logic [31:0] d);
        bus_word = w; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] w, output logic [31:0] d);
        bus_word = w; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic send(input int len, input logic [5:0] err, input bit with_sop);
        int beats;
        beats = (len + LANES - 1) / LANES;
        for (int b = 0; b < beats; b++) begin
            st_valid = 1'b1;
            st_sop   = with_sop && (b == 0);
            st_eop   = (b == beats - 1);
            st_empty = st_eop ? EW'(beats * LANES - len) : '0;
            st_err   = st_eop ? err : '0;
            @(negedge clk);
        end
        st_valid = 1'b0; st_sop = 1'b0; st_eop = 1'b0; st_err = '0; st_empty = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int exp_bytes, exp_good, exp_bad;
        logic [5:0] last_err;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: all registers zero after reset
        for (int w = 0; w < 8; w++) begin
            rd(3'(w), v);
            chk("R1 reset value", v, 32'd0);
        end

        // R2: target writable, counter words read-only
        wr(3'd0, NPKT);
        @(negedge clk);
        rd(3'd0, v);  chk("R2 target readback", v, NPKT);
        wr(3'd1, 32'h55);
        @(negedge clk);
        rd(3'd1, v);  chk("R2 good count ignores write", v, 32'd0);

        // R3: START visible for one cycle then clears
        wr(3'd7, 32'h1);
        rd(3'd7, v);  chk("R3 start reads one", v, 32'h1);
        rd(3'd7, v);  chk("R3 start self-clears", v, 32'h0);

        // R12: closing beat without an opening marker is ignored
        send(4, 6'd0, 1'b0);
        rd(3'd1, v);  chk("R12 headless beat good", v, 32'd0);
        rd(3'd3, v);  chk("R12 headless beat bytes", v, 32'd0);

        // R6 R7 R9 R10: sweep lengths 1..NPKT over every empty value
        exp_bytes = 0; exp_good = 0; exp_bad = 0; last_err = '0;
        for (int i = 0; i < NPKT; i++) begin
            logic [5:0] e;
            e = (i % 3 == 2) ? 6'(i) : 6'd0;
            if (i == NPKT - 1) begin
                rd(3'd7, v);
                chk("R9 done still low", v & 32'h4, 32'h0);
            end
            send(i + 1, e, 1'b1);
            exp_bytes += i + 1;
            if (e == 0) exp_good++; else exp_bad++;
            last_err = e;
        end
        @(negedge clk);
        rd(3'd1, v);  chk("R6 good count", v, exp_good);
        rd(3'd2, v);  chk("R6 errored count", v, exp_bad);
        rd(3'd3, v);  chk("R7 byte total low", v, exp_bytes);
        rd(3'd4, v);  chk("R11 byte total high", v, 32'd0);
        rd(3'd7, v);
        chk("R10 R9 status word", v,
            (32'(last_err) << 4) | (32'(last_err[1]) << 3) | 32'h4);

        // R9 R8: after done, packets ignored and cycle total holds
        rd(3'd5, v2);
        send(8, 6'd0, 1'b1);
        repeat (3) @(negedge clk);
        rd(3'd1, v);  chk("R9 good after done", v, exp_good);
        rd(3'd5, v);  chk("R8 cycles hold after done", v, v2);

        // R5: new run clears counters, keeps target
        wr(3'd7, 32'h1);
        @(negedge clk);
        rd(3'd1, v);  chk("R5 good cleared", v, 32'd0);
        rd(3'd3, v);  chk("R5 bytes cleared", v, 32'd0);
        rd(3'd7, v);  chk("R5 status cleared", v, 32'd0);
        rd(3'd0, v);  chk("R5 target kept", v, NPKT);

        // R4: stop sets STOP and halts counting
        wr(3'd7, 32'h2);
        @(negedge clk);
        rd(3'd7, v);  chk("R4 stop bit set", v, 32'h2);
        send(5, 6'd0, 1'b1);
        rd(3'd1, v);  chk("R4 good after stop", v, 32'd0);

        // R8: cycle total over an exact window
        wr(3'd7, 32'h1);
        repeat (WIN) @(negedge clk);
        wr(3'd7, 32'h2);
        @(negedge clk);
        rd(3'd5, v);  chk("R8 cycle window", v, WIN);
        rd(3'd6, v);  chk("R11 cycle high via shadow", v, 32'd0);

        // R4: next start clears STOP
        wr(3'd7, 32'h1);
        @(negedge clk);
        rd(3'd7, v);  chk("R4 start clears stop", v, 32'h0);

        // R7: one mid-run packet with a partial closing beat
        send(6, 6'd0, 1'b1);
        rd(3'd3, v);  chk("R7 partial beat bytes", v, 32'd6);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule